// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether a single I/O port access may proceed. A request names a 16-bit port, an access width of one, two or four bytes, and the processor's current mode and privilege state. When the state demands it, the block reads the relevant bytes of a permission bitmap through a simple memory read port and reports one of two verdicts: grant or general-protection fault.

Each bitmap bit stands for one port, and a set bit forbids access to that port. The bitmap's base address and its highest valid byte index are inputs, so the structure that holds the bitmap stays outside the block. The unit takes one request at a time. Its verdict comes out as a one-cycle pulse, after which the unit returns to idle.

Top module: `io_perm_check`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ready` is 1 and `done`, `allow`, `gpFault` and `memRdEn` are 0.
- R2: When `protEn` is 0, or when `protEn` is 1 with `v86Mode` 0 and `cpl` <= `iopl`, an accepted request completes with `done` and `allow` high in the cycle after acceptance. No bitmap read is made.
- R3: When `protEn` is 1 and either `cpl` > `iopl` or `v86Mode` is 1, the bitmap is consulted. With `v86Mode` high this holds whatever the value of `iopl`.
- R4: The permission bit for port p is bit p[2:0] of the bitmap byte at address `mapBase + (p >> 3)`. Bit 0 belongs to the lowest port of that byte.
- R5: `accSize` 00 selects 1 byte, 01 selects 2 bytes, and 10 or 11 select 4 bytes. An N-byte access at port P covers ports P to P+N-1. If any of their bits is 1, the result is `gpFault`; otherwise it is `allow`.
- R6: When the covered ports span two bitmap bytes, the block reads both of them in two consecutive cycles, the lower address first.
- R7: On a lookup, an access whose last port would pass 65535 faults without any bitmap read.
- R8: On a lookup, an access that touches a bitmap byte whose index exceeds `mapLimit` faults without any bitmap read.
- R9: `done` lasts one cycle. During it exactly one of `allow` and `gpFault` is high, and `faultCode` is 0. Outside `done` both verdict outputs are low.
- R10: `memRdData` is taken to be valid one cycle after `memRdEn`. A lookup that reads one bitmap byte signals `done` 3 cycles after acceptance, and one that reads two bytes signals it 4 cycles after.
- R11: A request is accepted only on a clock edge where `start` and `ready` are both high. A `start` raised while the unit is busy, including during `done`, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when `ready` is high |
| ready | output | 1 | Unit idle and able to accept a request |
| protEn | input | 1 | Protected mode enabled |
| v86Mode | input | 1 | Virtual-8086 mode active |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| port | input | 16 | First port of the access |
| accSize | input | 2 | Access width code (00=1, 01=2, 1x=4 bytes) |
| mapBase | input | 16 | Address of bitmap byte 0 |
| mapLimit | input | 13 | Highest valid bitmap byte index |
| memRdEn | output | 1 | Bitmap read request |
| memAddr | output | 16 | Bitmap read address |
| memRdData | input | 8 | Bitmap byte, valid one cycle after `memRdEn` |
| done | output | 1 | One-cycle verdict pulse |
| allow | output | 1 | Access granted (with `done`) |
| gpFault | output | 1 | General-protection fault (with `done`) |
| faultCode | output | 16 | Fault error code, always zero |

## Verification
When an access spans two bitmap bytes, two things happen in one cycle: the second bitmap read is issued, and the first byte's data comes back and is checked against the access mask. The bench triggers this with word and doubleword accesses that end just past a byte boundary. It places the forbidding bit in the first byte in one case, in the second byte in another, and in neither in a third. For each case it checks the verdict, the order of the two read addresses and the four-cycle latency. A second overlap happens when a new `start` is raised during a busy period and during the `done` cycle. The bench checks that the verdict still belongs to the original request and that no later read or pulse appears.

// File: rtl/io_perm_pkg.sv
package io_perm_pkg;

  localparam int PL_W = 2;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_WIDE  = 2'b11
  } accSize_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_FIRST,
    ST_RD_SECOND,
    ST_LAST,
    ST_RESP
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new request
    logic rdSecond;  // address the upper bitmap byte
    logic accum;     // fold returned bitmap byte into hit flag
    logic selHi;     // returned byte belongs to the upper mask half
  } ctlStrobe_t;

endpackage

// File: rtl/io_perm_datapath.sv
module io_perm_datapath
  import io_perm_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int ADDR_W = 16,
  localparam int IDX_W = PORT_W - 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              protEn,
  input  logic              v86Mode,
  input  logic [PL_W-1:0]   cpl,
  input  logic [PL_W-1:0]   iopl,
  input  logic [PORT_W-1:0] port,
  input  logic [1:0]        accSize,
  input  logic [ADDR_W-1:0] mapBase,
  input  logic [IDX_W-1:0]  mapLimit,
  input  logic [7:0]        memRdData,
  output logic              reqNeedCheck,
  output logic              reqReject,
  output logic              reqSpanTwo,
  output logic [ADDR_W-1:0] memAddr,
  output logic              grantOk
);

  logic [3:0]       numBytes;
  logic [7:0]       lenMask;
  logic [15:0]      portMask;
  logic [IDX_W-1:0] firstIdx, lastIdx;
  logic             wrapHit;

  logic [IDX_W-1:0] firstIdxR, lastIdxR;
  logic [15:0]      maskR;
  logic             needR, rejectR, hitR;
  logic [7:0]       maskSel;

  always_comb begin
    unique case (accSize_e'(accSize))
      SZ_BYTE: begin numBytes = 4'd1; lenMask = 8'h01; end
      SZ_WORD: begin numBytes = 4'd2; lenMask = 8'h03; end
      default: begin numBytes = 4'd4; lenMask = 8'h0F; end
    endcase
  end

  assign portMask     = {8'h00, lenMask} << port[2:0];
  assign firstIdx     = port[PORT_W-1:3];
  assign reqSpanTwo   = ({1'b0, port[2:0]} + numBytes) > 4'd8;
  assign lastIdx      = firstIdx + IDX_W'(reqSpanTwo);
  assign wrapHit      = (&firstIdx) && reqSpanTwo;
  assign reqNeedCheck = protEn && ((cpl > iopl) || v86Mode);
  assign reqReject    = wrapHit || (lastIdx > mapLimit);

  assign maskSel = strobe.selHi ? maskR[15:8] : maskR[7:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstIdxR <= '0;
      lastIdxR  <= '0;
      maskR     <= '0;
      needR     <= 1'b0;
      rejectR   <= 1'b0;
      hitR      <= 1'b0;
    end else if (strobe.load) begin
      firstIdxR <= firstIdx;
      lastIdxR  <= lastIdx;
      maskR     <= portMask;
      needR     <= reqNeedCheck;
      rejectR   <= reqReject;
      hitR      <= 1'b0;
    end else if (strobe.accum) begin
      hitR <= hitR | (|(memRdData & maskSel));
    end
  end

  assign memAddr = mapBase + ADDR_W'(strobe.rdSecond ? lastIdxR : firstIdxR);
  assign grantOk = !needR || (!rejectR && !hitR);

endmodule

// File: rtl/io_perm_control.sv
module io_perm_control
  import io_perm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       reqNeedCheck,
  input  logic       reqReject,
  input  logic       reqSpanTwo,
  output ctlStrobe_t strobe,
  output logic       memRdEn,
  output logic       ready,
  output logic       done
);

  state_e state, stateNxt;
  logic   twoR;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    memRdEn  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateNxt = (!reqNeedCheck || reqReject) ? ST_RESP : ST_RD_FIRST;
        end
      end
      ST_RD_FIRST: begin
        memRdEn  = 1'b1;
        stateNxt = twoR ? ST_RD_SECOND : ST_LAST;
      end
      ST_RD_SECOND: begin
        memRdEn         = 1'b1;
        strobe.rdSecond = 1'b1;
        strobe.accum    = 1'b1;
        stateNxt        = ST_LAST;
      end
      ST_LAST: begin
        strobe.accum = 1'b1;
        strobe.selHi = twoR;
        stateNxt     = ST_RESP;
      end
      ST_RESP: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      twoR  <= 1'b0;
    end else begin
      state <= stateNxt;
      if (strobe.load) twoR <= reqSpanTwo;
    end
  end

  assign ready = (state == ST_IDLE);
  assign done  = (state == ST_RESP);

endmodule

// File: rtl/io_perm_check.sv
module io_perm_check
  import io_perm_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int ADDR_W = 16,
  parameter int CODE_W = 16,
  localparam int IDX_W = PORT_W - 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              ready,
  input  logic              protEn,
  input  logic              v86Mode,
  input  logic [1:0]        cpl,
  input  logic [1:0]        iopl,
  input  logic [PORT_W-1:0] port,
  input  logic [1:0]        accSize,
  input  logic [ADDR_W-1:0] mapBase,
  input  logic [IDX_W-1:0]  mapLimit,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdData,
  output logic              done,
  output logic              allow,
  output logic              gpFault,
  output logic [CODE_W-1:0] faultCode
);

  ctlStrobe_t strobe;
  logic       reqNeedCheck, reqReject, reqSpanTwo, grantOk;

  io_perm_control uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .reqNeedCheck(reqNeedCheck), .reqReject(reqReject), .reqSpanTwo(reqSpanTwo),
    .strobe(strobe), .memRdEn(memRdEn), .ready(ready), .done(done)
  );

  io_perm_datapath #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .protEn(protEn), .v86Mode(v86Mode), .cpl(cpl), .iopl(iopl),
    .port(port), .accSize(accSize), .mapBase(mapBase), .mapLimit(mapLimit),
    .memRdData(memRdData),
    .reqNeedCheck(reqNeedCheck), .reqReject(reqReject), .reqSpanTwo(reqSpanTwo),
    .memAddr(memAddr), .grantOk(grantOk)
  );

  assign allow     = done && grantOk;
  assign gpFault   = done && !grantOk;
  assign faultCode = '0;

endmodule

// File: rtl/io_perm_check_props.sv
module io_perm_check_props #(
  parameter int PORT_W = 16,
  localparam int IDX_W = PORT_W - 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              ready,
  input logic              protEn,
  input logic              v86Mode,
  input logic [1:0]        cpl,
  input logic [1:0]        iopl,
  input logic [PORT_W-1:0] port,
  input logic [1:0]        accSize,
  input logic [IDX_W-1:0]  mapLimit,
  input logic              memRdEn,
  input logic              done,
  input logic              allow,
  input logic              gpFault
);

  p_verdict_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (allow ^ gpFault));

  p_verdict_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (!allow && !gpFault));

  p_real_grant_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && ready && !protEn) |=> (done && allow && !memRdEn));

  p_priv_grant_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && ready && protEn && !v86Mode && (cpl <= iopl)) |=> (done && allow));

  p_v86_lookup_r3: assert property (@(posedge clk) disable iff (!rstN)
    (start && ready && protEn && v86Mode && accSize == 2'b00
     && port[PORT_W-1:3] <= mapLimit) |=> memRdEn);

  p_wrap_deny_r7: assert property (@(posedge clk) disable iff (!rstN)
    (start && ready && protEn && v86Mode && (&port) && accSize != 2'b00)
    |=> (done && gpFault));

  p_read_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> !ready);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (ready && !done));

  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && !done) |=> !ready);

endmodule

bind io_perm_check io_perm_check_props #(.PORT_W(PORT_W)) uProps (
  .clk(clk), .rstN(rstN), .start(start), .ready(ready),
  .protEn(protEn), .v86Mode(v86Mode), .cpl(cpl), .iopl(iopl),
  .port(port), .accSize(accSize), .mapLimit(mapLimit),
  .memRdEn(memRdEn), .done(done), .allow(allow), .gpFault(gpFault)
);

// File: tb/io_perm_check_test.sv
module io_perm_check_test;

  localparam logic [15:0] BASE = 16'h0400;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        ready;
  logic        protEn = 1'b0, v86Mode = 1'b0;
  logic [1:0]  cpl = 2'd0, iopl = 2'd0;
  logic [15:0] port = '0;
  logic [1:0]  accSize = 2'b00;
  logic [15:0] mapBase = BASE;
  logic [12:0] mapLimit = 13'd255;
  logic        memRdEn;
  logic [15:0] memAddr;
  logic [7:0]  memRdData;
  logic        done, allow, gpFault;
  logic [15:0] faultCode;

  int nTests = 0;
  int nFail  = 0;

  logic [7:0]  bmp [0:255];
  int          rdCnt = 0;
  logic [15:0] lastAddr = '0, prevAddr = '0;

  always #10 clk = ~clk;

  io_perm_check uut (
    .clk(clk), .rstN(rstN), .start(start), .ready(ready),
    .protEn(protEn), .v86Mode(v86Mode), .cpl(cpl), .iopl(iopl),
    .port(port), .accSize(accSize), .mapBase(mapBase), .mapLimit(mapLimit),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .done(done), .allow(allow), .gpFault(gpFault), .faultCode(faultCode)
  );

  function automatic logic [7:0] memByte(logic [15:0] a);
    if (a >= BASE && a < BASE + 16'd256) return bmp[a - BASE];
    return 8'hFF;
  endfunction

  always_ff @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= memByte(memAddr);
      prevAddr  <= lastAddr;
      lastAddr  <= memAddr;
      rdCnt     <= rdCnt + 1;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one request, compute the expected verdict independently, check all
  task automatic runReq(string req, bit pe, bit vm, int cp, int io,
                        int p, int sz, bit busyPoke);
    int n, lat, baseCnt, expReads, expLat, idx0, idx1;
    bit expOk, lookup;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    lookup = pe && ((cp > io) || vm);
    idx0 = p >> 3;
    idx1 = (p + n - 1) >> 3;
    expOk = 1'b1;
    expReads = 0;
    if (lookup) begin
      if (p + n - 1 > 65535 || idx1 > int'(mapLimit)) expOk = 1'b0;
      else begin
        expReads = (idx1 != idx0) ? 2 : 1;
        for (int q = p; q < p + n; q++)
          if (memByte(mapBase + 16'(q >> 3))[q & 7]) expOk = 1'b0;
      end
    end
    expLat = (expReads == 0) ? 1 : expReads + 2;

    @(negedge clk);
    protEn = pe; v86Mode = vm; cpl = 2'(cp); iopl = 2'(io);
    port = 16'(p); accSize = 2'(sz); start = 1'b1;
    baseCnt = rdCnt;
    @(posedge clk);
    @(negedge clk);
    if (!busyPoke) start = 1'b0;
    else port = 16'd20;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(allow == expOk, req, "allow", int'(allow), int'(expOk));
    check(gpFault == !expOk, req, "gpFault", int'(gpFault), int'(!expOk));
    check(faultCode == 16'd0, "R9", "faultCode", int'(faultCode), 0);
    check(lat == expLat, req, "latency", lat, expLat);
    check(rdCnt - baseCnt == expReads, req, "reads", rdCnt - baseCnt, expReads);
    if (expReads == 1)
      check(lastAddr == mapBase + 16'(idx0), req, "addr", int'(lastAddr),
            int'(mapBase) + idx0);
    if (expReads == 2) begin
      check(prevAddr == mapBase + 16'(idx0), req, "addr0", int'(prevAddr),
            int'(mapBase) + idx0);
      check(lastAddr == mapBase + 16'(idx1), req, "addr1", int'(lastAddr),
            int'(mapBase) + idx1);
    end
    @(negedge clk);
    check(!done && ready, "R9", "done one cycle", int'(done), 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(ready && !done && !allow && !gpFault && !memRdEn, "R1",
          "reset outputs", int'({ready, done, allow, gpFault, memRdEn}), 16);
    rstN = 1'b1;
    @(negedge clk);
    check(ready && !done && !memRdEn, "R1", "after reset",
          int'({ready, done, memRdEn}), 4);
  endtask

  task automatic testNoLookup();
    runReq("R2", 0, 0, 3, 0, 20, 0, 0);  // real mode, forbidden port
    runReq("R2", 0, 1, 3, 0, 20, 0, 0);  // v86 flag without protection
    runReq("R2", 1, 0, 0, 3, 20, 0, 0);  // cpl below iopl
    runReq("R2", 1, 0, 2, 2, 20, 2, 0);  // cpl equal iopl
  endtask

  task automatic testLookup();
    runReq("R3", 1, 0, 3, 0, 20, 0, 0);  // bit set, fault
    runReq("R4", 1, 0, 3, 0, 21, 0, 0);  // neighbour bit clear
    runReq("R3", 1, 1, 3, 3, 20, 0, 0);  // v86 ignores iopl
    runReq("R10", 1, 1, 0, 3, 40, 0, 0); // v86 at cpl 0
  endtask

  task automatic testSizes();
    runReq("R5", 1, 0, 3, 0, 19, 1, 0);
    runReq("R5", 1, 0, 3, 0, 18, 1, 0);
    runReq("R5", 1, 0, 3, 0, 16, 2, 0);
    runReq("R5", 1, 0, 3, 0, 17, 2, 0);
    runReq("R5", 1, 0, 3, 0, 17, 3, 0);
    runReq("R5", 1, 0, 3, 0, 16, 3, 0);
  endtask

  task automatic testStraddle();
    runReq("R6", 1, 0, 3, 0, 39, 1, 0);  // hit in first byte
    runReq("R6", 1, 0, 3, 0, 45, 2, 0);  // hit in second byte
    runReq("R6", 1, 0, 3, 0, 55, 1, 0);  // no hit, two reads
    runReq("R6", 1, 0, 3, 0, 38, 1, 0);  // single byte, bit 7
  endtask

  task automatic testWrap();
    mapLimit = 13'h1FFF;
    runReq("R7", 1, 1, 3, 0, 16'hFFFF, 1, 0);
    runReq("R7", 1, 1, 3, 0, 16'hFFFD, 2, 0);
    runReq("R7", 1, 1, 3, 0, 16'hFFFC, 2, 0);
    mapLimit = 13'd255;
  endtask

  task automatic testLimit();
    mapLimit = 13'd5;
    runReq("R8", 1, 0, 3, 0, 47, 0, 0);
    runReq("R8", 1, 0, 3, 0, 47, 1, 0);
    runReq("R8", 1, 0, 3, 0, 48, 0, 0);
    mapLimit = 13'd255;
  endtask

  task automatic testBusy();
    int cnt0;
    runReq("R11", 1, 0, 3, 0, 55, 1, 1);
    cnt0 = rdCnt;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!done && ready, "R11", "no stray pulse", int'(done), 0);
    end
    check(rdCnt == cnt0, "R11", "no stray read", rdCnt - cnt0, 0);
    runReq("R11", 1, 0, 3, 0, 21, 0, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmp[i] = 8'h00;
    bmp[2] = 8'h10;  // port 20
    bmp[4] = 8'h80;  // port 39
    bmp[5] = 8'h01;  // port 40
    bmp[6] = 8'h01;  // port 48
    memRdData = 8'h00;
    testReset();
    testNoLookup();
    testLookup();
    testSizes();
    testStraddle();
    testWrap();
    testLimit();
    testBusy();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #4000000;
    nTests++;
    nFail++;
    $display("FAIL watchdog run did not finish");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule